// File: doc/BRIEF.md
# Dual-Pattern Serial Bit Detector

This block watches a serial stream one bit at a time and flags every position at which the four most recently accepted bits spell either `1100` or `1011`. Matches may overlap, so the trailing bits of one hit can start the next. A `1011` hit followed by `00` therefore reports a `1100` hit two accepted bits later.

The detect output is Mealy style. It is a combinational function of the stored state and the bit being presented. It rises in the same cycle that the final bit of a pattern sits on the input, before that bit is registered.

The input side is a stream with a valid qualifier. A bit is consumed on a rising clock edge only when `in_valid` is high. The detector accepts a bit on every cycle, so it never applies back-pressure and has no ready output. A producer may present a bit on any cycle and it is taken at once. Cycles with `in_valid` low are bubbles: the bit is ignored, the state holds, and `detect` stays low. Reset is synchronous and active high.

Top module: `seqdet_dual`

## Requirements
- R1: While `rst` is high, `detect` is 0. One clock edge with `rst` high returns the machine to idle, where no bit of either pattern has been seen.
- R2: `detect` is 1 in the cycle an accepted bit completes `1100` as the last four accepted bits. Here the oldest bit is the leftmost and the presented bit is the rightmost.
- R3: `detect` is 1 in the cycle an accepted bit completes `1011` as the last four accepted bits, with the same ordering as R2.
- R4: For any other four-bit window, for example `1110`, `0011`, `1001`, `0101` or `1010`, `detect` is 0.
- R5: Overlapping matches are all reported. For example, `101100` detects on bits 4 and 6, and `1011011` detects on bits 4 and 7.
- R6: A run of three or more 1s followed by `00` reports a `1100` hit on the second 0.
- R7: Fewer than four bits accepted since reset never produce a detection. Bits accepted before a reset do not count toward a later match.
- R8: With `in_valid` low, the presented bit is ignored, `detect` is 0 and the pattern progress is kept. A match spanning a bubble is still reported.
- R9: The input stream `11110000101101100` yields the output stream `00000100000100101`, bit for bit.
- R10: For arbitrary streams with random bubbles, `detect` equals the four-bit-window rule of R2, R3, R7 and R8 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when `in_bit` carries a bit to consume this cycle |
| in_bit | input | 1 | Serial data bit |
| detect | output | 1 | Mealy match flag for the bit currently presented |

## Verification
The bench targets the overlap chains where one pattern feeds the other. A design that cleared to idle after a hit would miss the second detection in `101100` or `1011011`. It also drives long runs of 1s, where a machine that fell out of the `11` progress state would lose the `1100` that follows. Bubbles inserted mid-pattern catch a design that advances or resets on invalid cycles. Short streams after a reset, including one that would complete a pattern only with bits from before the reset, expose a design that reports windows it has not fully seen or that keeps history across reset.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
  localparam int PAT_LEN = 4;
  localparam logic [PAT_LEN-1:0] PAT_A = 4'b1100;
  localparam logic [PAT_LEN-1:0] PAT_B = 4'b1011;

  // Each state names the longest tail of the accepted history
  // that is also a head of one of the two patterns.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_1    = 3'd1,
    ST_11   = 3'd2,
    ST_110  = 3'd3,
    ST_10   = 3'd4,
    ST_101  = 3'd5
  } seq_state_e;
endpackage

// File: rtl/seqdet_next.sv
module seqdet_next
  import seqdet_pkg::*;
(
  input  seq_state_e cur,
  input  logic       in_bit,
  output seq_state_e nxt,
  output logic       hit
);
  always_comb begin
    nxt = ST_IDLE;
    hit = 1'b0;
    unique case (cur)
      ST_IDLE: nxt = in_bit ? ST_1 : ST_IDLE;
      ST_1:    nxt = in_bit ? ST_11 : ST_10;
      ST_11:   nxt = in_bit ? ST_11 : ST_110;
      ST_110: begin
        if (in_bit) begin
          nxt = ST_101;          // 1101 -> tail 101
        end else begin
          nxt = ST_IDLE;         // 1100 complete
          hit = 1'b1;
        end
      end
      ST_10:   nxt = in_bit ? ST_101 : ST_IDLE;
      ST_101: begin
        if (in_bit) begin
          nxt = ST_11;           // 1011 complete, tail 11 kept
          hit = 1'b1;
        end else begin
          nxt = ST_10;           // 1010 -> tail 10
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/seqdet_state_reg.sv
module seqdet_state_reg
  import seqdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  seq_state_e nxt,
  output seq_state_e cur
);
  always_ff @(posedge clk) begin
    if (rst)       cur <= ST_IDLE;
    else if (load) cur <= nxt;
  end
endmodule

// File: rtl/seqdet_dual.sv
module seqdet_dual
  import seqdet_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic detect
);
  seq_state_e cur_st;
  seq_state_e nxt_st;
  logic       raw_hit;

  seqdet_next u_next (
    .cur    (cur_st),
    .in_bit (in_bit),
    .nxt    (nxt_st),
    .hit    (raw_hit)
  );

  seqdet_state_reg u_reg (
    .clk  (clk),
    .rst  (rst),
    .load (in_valid),
    .nxt  (nxt_st),
    .cur  (cur_st)
  );

  assign detect = raw_hit & in_valid & ~rst;

  // Checking only: accepted-bit count since reset, saturating at PAT_LEN-1.
  logic [1:0] seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else if (in_valid && seen_q != 2'(PAT_LEN-1)) seen_q <= seen_q + 2'd1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (cur_st == ST_IDLE));

  assert_after_a_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (detect && !in_bit) |=> (cur_st == ST_IDLE));

  assert_after_b_keeps_11_R5: assert property (@(posedge clk) disable iff (rst)
    (detect && in_bit) |=> (cur_st == ST_11));

  assert_no_early_hit_R7: assert property (@(posedge clk) disable iff (rst)
    detect |-> (seen_q == 2'(PAT_LEN-1)));

  assert_bubble_holds_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(cur_st));

  assert_ones_stay_R6: assert property (@(posedge clk) disable iff (rst)
    (cur_st == ST_11 && in_valid && in_bit) |=> (cur_st == ST_11));
endmodule

// File: tb/sim_seqdet_dual.sv
`timescale 1ns/1ps
module sim_seqdet_dual;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic detect;

  int checks = 0;
  int errors = 0;
  logic [3:0] hist = '0;
  int seen = 0;

  always #5 clk = ~clk;

  seqdet_dual u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit), .detect(detect)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: detect=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Presents one bit, checks detect against the window model, then updates it.
  task automatic step(input logic b, input logic v, input string tag, output logic got);
    logic [3:0] w;
    logic exp;
    @(negedge clk);
    in_bit = b;
    in_valid = v;
    #1;
    w = {hist[2:0], b};
    exp = v && (seen >= 3) && (w == 4'b1100 || w == 4'b1011);
    got = detect;
    check(detect, exp, tag);
    if (v) begin
      hist = w;
      if (seen < 3) seen++;
    end
  endtask

  task automatic feed(input logic [15:0] bits, input int n, input string tag);
    logic g;
    for (int i = n - 1; i >= 0; i--) step(bits[i], 1'b1, tag, g);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    in_bit = 1'b1;
    #1;
    check(detect, 1'b0, "R1 detect low in reset");
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    hist = '0;
    seen = 0;
  endtask

  task automatic test_reset();
    logic g;
    do_reset();
    // After reset: 1100 must need all four bits again (idle state).
    step(1'b0, 1'b1, "R1 idle after reset", g);
    step(1'b0, 1'b1, "R1 idle after reset", g);
    check(g, 1'b0, "R1 no hit from zeros");
  endtask

  task automatic test_pat_a();
    logic g;
    do_reset();
    feed(16'b110, 3, "R2 prefix");
    step(1'b0, 1'b1, "R2 1100", g);
    check(g, 1'b1, "R2 1100 hits on last bit");
  endtask

  task automatic test_pat_b();
    logic g;
    do_reset();
    feed(16'b101, 3, "R3 prefix");
    step(1'b1, 1'b1, "R3 1011", g);
    check(g, 1'b1, "R3 1011 hits on last bit");
  endtask

  task automatic test_nomatch();
    do_reset();
    feed(16'b1110, 4, "R4 1110");
    do_reset();
    feed(16'b0011, 4, "R4 0011");
    do_reset();
    feed(16'b1001, 4, "R4 1001");
    do_reset();
    feed(16'b0101, 4, "R4 0101");
    do_reset();
    feed(16'b1010, 4, "R4 1010");
  endtask

  task automatic test_overlap();
    logic g;
    do_reset();
    feed(16'b10110, 5, "R5 101100");
    step(1'b0, 1'b1, "R5 chained 1100", g);
    check(g, 1'b1, "R5 1011 then 00 hits again");
    do_reset();
    feed(16'b101101, 6, "R5 1011011");
    step(1'b1, 1'b1, "R5 second 1011", g);
    check(g, 1'b1, "R5 1011011 hits at bit 7");
  endtask

  task automatic test_ones_run();
    logic g;
    do_reset();
    feed(16'b1111110, 7, "R6 run of ones");
    step(1'b0, 1'b1, "R6 1100 after long run", g);
    check(g, 1'b1, "R6 hit after six 1s and 00");
  endtask

  task automatic test_short();
    logic g;
    do_reset();
    feed(16'b101, 3, "R7 pre-reset history");
    do_reset();
    step(1'b1, 1'b1, "R7 first bit after reset", g);
    check(g, 1'b0, "R7 history before reset ignored");
    step(1'b1, 1'b1, "R7 short", g);
    step(1'b0, 1'b1, "R7 short", g);
    check(g, 1'b0, "R7 three bits never hit");
  endtask

  task automatic test_bubble();
    logic g;
    do_reset();
    step(1'b1, 1'b1, "R8 bubble", g);
    step(1'b0, 1'b1, "R8 bubble", g);
    step(1'b0, 1'b0, "R8 ignored 0", g);
    step(1'b1, 1'b0, "R8 ignored 1", g);
    step(1'b1, 1'b1, "R8 bubble", g);
    step(1'b1, 1'b0, "R8 invalid would-complete", g);
    check(g, 1'b0, "R8 invalid bit gives no hit");
    step(1'b1, 1'b1, "R8 1011 across bubbles", g);
    check(g, 1'b1, "R8 match spans bubbles");
  endtask

  task automatic test_example();
    logic [16:0] ex_in  = 17'b11110000101101100;
    logic [16:0] ex_out = 17'b00000100000100101;
    logic g;
    do_reset();
    for (int i = 16; i >= 0; i--) begin
      step(ex_in[i], 1'b1, "R9 example stream", g);
      check(g, ex_out[i], "R9 example output vector");
    end
  endtask

  task automatic test_random();
    logic g;
    do_reset();
    for (int i = 0; i < 2000; i++) begin
      if (i % 500 == 499) do_reset();
      step(1'($urandom_range(0, 1)), ($urandom_range(0, 4) != 0), "R10 random", g);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    test_reset();
    test_pat_a();
    test_pat_b();
    test_nomatch();
    test_overlap();
    test_ones_run();
    test_short();
    test_bubble();
    test_example();
    test_random();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: done=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule